// File: doc/BRIEF.md
# Register-Machine ALU Execute Stage

This block is the arithmetic/logic execute stage of a two-operand virtual-machine core with 64-bit registers. Each cycle it may accept one instruction: an 8-bit opcode, the current value of the destination register, the value of the source register, a 32-bit immediate and the index of the destination register. One clock later it presents the result, a write-enable and the destination index for the register file. The register file, instruction fetch, memory access and branching are elsewhere.

A single operation table serves two instruction classes. The 64-bit class works on full register values. The 32-bit class works on the low halves and zero-extends its result. One opcode bit chooses whether the second operand is the source register or the immediate. A byte-order conversion operation rearranges or truncates the destination value to 16, 32 or 64 bits. Opcodes that fall outside the table raise an illegal-instruction flag and write nothing. Register 10 is a read-only frame pointer and is never written.

Top module: `vm_alu_exec`

## Requirements
- R1: Only class values 0x4 (opcode bits [2:0], 32-bit class) and 0x7 (64-bit class) are legal, with operation codes 0x0 to 0xD in opcode bits [7:4]. Any other class or operation code sets `out_illegal`, clears `out_wr_en` and gives `out_result` 0.
- R2: Opcode bit 3 selects the second operand. A 1 picks `src_val`. A 0 picks the immediate.
- R3: In the 64-bit class the immediate is sign-extended from bit 31. In the 32-bit class only its 32 bits are used.
- R4: A 32-bit class operation other than byte-order conversion reads only bits [31:0] of each operand, and its result has bits [63:32] equal to zero.
- R5: Operation codes: 0 add, 1 sub, 2 mul, 3 unsigned div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate the destination, 9 unsigned modulo, A xor, B move the second operand, C arithmetic right shift, D byte-order conversion.
- R6: The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R7: Division by zero gives 0. Modulo by zero returns the destination value, truncated to 32 bits in the 32-bit class.
- R8: Byte-order conversion takes its width (16, 32 or 64) from the immediate and works on the low bits of the destination value of that width. With opcode bit 3 set, it reverses the byte order within that width. With bit 3 clear, it keeps the bytes as they are. In both cases the upper bits are zero.
- R9: A byte-order conversion whose immediate is not 16, 32 or 64 is illegal, as in R1.
- R10: A legal operation whose destination index is 10 or above is not written (`out_wr_en` low), while `out_result` still carries the computed value.
- R11: Results appear exactly one cycle after `in_valid`. `out_valid` follows `in_valid` with that delay, and `out_wr_idx` echoes the destination index.
- R12: While reset is active and after it is released, `out_valid`, `out_wr_en`, `out_illegal` and `out_result` are all zero until the first instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation [7:4], operand select [3], class [2:0] |
| dst_idx | input | 4 | Destination register index |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Computed value |
| out_wr_en | output | 1 | Write the result to the register file |
| out_wr_idx | output | 4 | Register index to write |
| out_illegal | output | 1 | Instruction was not a legal ALU operation |

## Verification
The two functions that can fall in the same cycle are computing the result and suppressing the write to the frame pointer. An instruction aimed at register 10 must still deliver its computed value on `out_result` while `out_wr_en` stays low. Directed instructions provoke this with add, byte-order conversion and an illegal opcode, all aimed at index 10. Random traffic also picks index 10 often. The result is compared with the bench model in every such cycle, and the bench's register model must show that register 10 never changes.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;
  localparam logic [2:0] CLS_W32 = 3'h4;
  localparam logic [2:0] CLS_W64 = 3'h7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_SAR  = 4'hC,
    OP_BSWP = 4'hD
  } alu_op_e;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_32 = 2'd1,
    SW_64 = 2'd2
  } swap_w_e;
endpackage

// File: rtl/vm_alu_opsel.sv
module vm_alu_opsel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              use_reg,
  input  logic              is64,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] b_val
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    if (is64) imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    else      imm_ext = {{EXT_W{1'b0}}, imm_val};
    b_val = use_reg ? src_val : imm_ext;
  end
endmodule

// File: rtl/vm_alu_bswap.sv
module vm_alu_bswap
  import vm_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val,
  input  logic              to_be,
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] res
);
  localparam int NB = DATA_W / 8;
  localparam int HB = NB / 2;
  localparam int HW = DATA_W / 2;

  logic [DATA_W-1:0] sw_full;
  logic [HW-1:0]     sw_half;
  logic [15:0]       sw_16;

  for (genvar i = 0; i < NB; i++) begin : g_full
    assign sw_full[8*i +: 8] = val[DATA_W-8-8*i +: 8];
  end
  for (genvar i = 0; i < HB; i++) begin : g_half
    assign sw_half[8*i +: 8] = val[HW-8-8*i +: 8];
  end
  assign sw_16 = {val[7:0], val[15:8]};

  always_comb begin
    res = '0;
    case (width_sel)
      SW_16:   res[15:0]   = to_be ? sw_16 : val[15:0];
      SW_32:   res[HW-1:0] = to_be ? sw_half : val[HW-1:0];
      default: res         = to_be ? sw_full : val;
    endcase
  end
endmodule

// File: rtl/vm_alu_core.sv
module vm_alu_core
  import vm_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [3:0]        op_code,
  input  logic              is64,
  input  logic              swap_be,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] res,
  output logic              bad_op
);
  localparam int HW    = DATA_W / 2;
  localparam int SH_W  = $clog2(DATA_W);
  localparam int SH_HW = $clog2(HW);

  logic [HW-1:0]     a_lo, b_lo, r_lo;
  logic [DATA_W-1:0] r_full, r_swap;
  logic [1:0]        sw_sel;
  logic              sw_bad;

  assign a_lo = a_val[HW-1:0];
  assign b_lo = b_val[HW-1:0];

  always_comb begin : full_path
    case (op_code)
      OP_ADD:  r_full = a_val + b_val;
      OP_SUB:  r_full = a_val - b_val;
      OP_MUL:  r_full = a_val * b_val;
      OP_DIV:  r_full = (b_val == '0) ? '0 : a_val / b_val;
      OP_OR:   r_full = a_val | b_val;
      OP_AND:  r_full = a_val & b_val;
      OP_SHL:  r_full = a_val << b_val[SH_W-1:0];
      OP_SHR:  r_full = a_val >> b_val[SH_W-1:0];
      OP_NEG:  r_full = '0 - a_val;
      OP_MOD:  r_full = (b_val == '0) ? a_val : a_val % b_val;
      OP_XOR:  r_full = a_val ^ b_val;
      OP_MOV:  r_full = b_val;
      OP_SAR:  r_full = $signed(a_val) >>> b_val[SH_W-1:0];
      default: r_full = '0;
    endcase
  end

  always_comb begin : half_path
    case (op_code)
      OP_ADD:  r_lo = a_lo + b_lo;
      OP_SUB:  r_lo = a_lo - b_lo;
      OP_MUL:  r_lo = a_lo * b_lo;
      OP_DIV:  r_lo = (b_lo == '0) ? '0 : a_lo / b_lo;
      OP_OR:   r_lo = a_lo | b_lo;
      OP_AND:  r_lo = a_lo & b_lo;
      OP_SHL:  r_lo = a_lo << b_lo[SH_HW-1:0];
      OP_SHR:  r_lo = a_lo >> b_lo[SH_HW-1:0];
      OP_NEG:  r_lo = '0 - a_lo;
      OP_MOD:  r_lo = (b_lo == '0) ? a_lo : a_lo % b_lo;
      OP_XOR:  r_lo = a_lo ^ b_lo;
      OP_MOV:  r_lo = b_lo;
      OP_SAR:  r_lo = $signed(a_lo) >>> b_lo[SH_HW-1:0];
      default: r_lo = '0;
    endcase
  end

  always_comb begin : swap_width
    sw_bad = 1'b0;
    if (imm_val == IMM_W'(16))          sw_sel = SW_16;
    else if (imm_val == IMM_W'(HW))     sw_sel = SW_32;
    else if (imm_val == IMM_W'(DATA_W)) sw_sel = SW_64;
    else begin
      sw_sel = SW_64;
      sw_bad = 1'b1;
    end
  end

  vm_alu_bswap #(.DATA_W(DATA_W)) u_swap (
    .val       (a_val),
    .to_be     (swap_be),
    .width_sel (sw_sel),
    .res       (r_swap)
  );

  always_comb begin : merge
    bad_op = (op_code > OP_BSWP) || ((op_code == OP_BSWP) && sw_bad);
    if (op_code == OP_BSWP) res = r_swap;
    else if (is64)          res = r_full;
    else                    res = {{HW{1'b0}}, r_lo};
  end
endmodule

// File: rtl/vm_alu_exec.sv
module vm_alu_exec
  import vm_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int IDX_W  = 4,
  parameter int FP_IDX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [IDX_W-1:0]  out_wr_idx,
  output logic              out_illegal
);
  localparam int HW    = DATA_W / 2;
  localparam int EXT_W = DATA_W - IMM_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // decode
  logic              is64, cls_ok, bad_op;
  logic [DATA_W-1:0] b_val, core_res;

  assign is64   = (opcode[2:0] == CLS_W64);
  assign cls_ok = (opcode[2:0] == CLS_W32) || is64;

  vm_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_reg (opcode[3]),
    .is64    (is64),
    .src_val (src_val),
    .imm_val (imm),
    .b_val   (b_val)
  );

  vm_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .op_code (opcode[7:4]),
    .is64    (is64),
    .swap_be (opcode[3]),
    .a_val   (dst_val),
    .b_val   (b_val),
    .imm_val (imm),
    .res     (core_res),
    .bad_op  (bad_op)
  );

  // next state
  logic              legal;
  logic              nxt_valid, nxt_we, nxt_ill;
  logic [DATA_W-1:0] nxt_res;

  always_comb begin
    legal     = cls_ok && !bad_op;
    nxt_valid = in_valid;
    nxt_ill   = in_valid && !legal;
    nxt_we    = in_valid && legal && (dst_idx < IDX_W'(FP_IDX));
    nxt_res   = legal ? core_res : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_wr_idx  <= '0;
    end else begin
      out_valid   <= nxt_valid;
      out_wr_en   <= nxt_we;
      out_illegal <= nxt_ill;
      if (in_valid) begin
        out_result <= nxt_res;
        out_wr_idx <= dst_idx;
      end
    end
  end

  // assertion support: set one cycle after reset release
  logic chk_armed;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) chk_armed <= 1'b0;
    else          chk_armed <= 1'b1;
  end

  // R10
  fp_guard_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_wr_en |-> (out_wr_idx < IDX_W'(FP_IDX)));

  // R1
  illegal_nowr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_illegal |-> (!out_wr_en && out_result == '0));

  // R11
  valid_wr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_wr_en || out_illegal) |-> out_valid);

  // R4
  zext_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (chk_armed && $past(in_valid && opcode[2:0] == CLS_W32 && opcode[7:4] != OP_BSWP))
      |-> (out_result[DATA_W-1:HW] == '0));

  // R3
  sext_mov_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (chk_armed && $past(in_valid && opcode == {OP_MOV, 1'b0, CLS_W64}))
      |-> (out_result == {{EXT_W{$past(imm[IMM_W-1])}}, $past(imm)}));
endmodule

// File: tb/sim_vm_alu_exec.sv
`timescale 1ns/1ps
module sim_vm_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [3:0]  dst_idx = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic        out_valid, out_wr_en, out_illegal;
  logic [63:0] out_result;
  logic [3:0]  out_wr_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  logic [63:0] regs [0:10];

  always #4 clk = ~clk;

  vm_alu_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .dst_idx(dst_idx), .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
    .out_wr_idx(out_wr_idx), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_calc(input logic [7:0] op, input logic [63:0] d,
                                   input logic [63:0] s, input logic [31:0] im,
                                   output logic ill, output logic [63:0] r);
    logic [2:0]  cls;
    logic [3:0]  code;
    logic        w64;
    logic [63:0] b;
    logic [31:0] x, y, z;
    cls = op[2:0];
    code = op[7:4];
    w64 = (cls == 3'd7);
    ill = 1'b0;
    r = 64'd0;
    b = op[3] ? s : (w64 ? {{32{im[31]}}, im} : {32'd0, im});
    if (cls != 3'd4 && cls != 3'd7) ill = 1'b1;
    else if (code > 4'd13) ill = 1'b1;
    else if (code == 4'd13) begin
      if (im == 32'd16)
        r = op[3] ? {48'd0, d[7:0], d[15:8]} : {48'd0, d[15:0]};
      else if (im == 32'd32)
        r = op[3] ? {32'd0, d[7:0], d[15:8], d[23:16], d[31:24]} : {32'd0, d[31:0]};
      else if (im == 32'd64) begin
        if (op[3]) for (int k = 0; k < 8; k++) r[8*k +: 8] = d[56-8*k +: 8];
        else r = d;
      end else ill = 1'b1;
    end else if (w64) begin
      case (code)
        4'd0:  r = d + b;
        4'd1:  r = d - b;
        4'd2:  r = d * b;
        4'd3:  r = (b == 0) ? 64'd0 : d / b;
        4'd4:  r = d | b;
        4'd5:  r = d & b;
        4'd6:  r = d << b[5:0];
        4'd7:  r = d >> b[5:0];
        4'd8:  r = -d;
        4'd9:  r = (b == 0) ? d : d % b;
        4'd10: r = d ^ b;
        4'd11: r = b;
        default: r = $signed(d) >>> b[5:0];
      endcase
    end else begin
      x = d[31:0];
      y = b[31:0];
      case (code)
        4'd0:  z = x + y;
        4'd1:  z = x - y;
        4'd2:  z = x * y;
        4'd3:  z = (y == 0) ? 32'd0 : x / y;
        4'd4:  z = x | y;
        4'd5:  z = x & y;
        4'd6:  z = x << y[4:0];
        4'd7:  z = x >> y[4:0];
        4'd8:  z = -x;
        4'd9:  z = (y == 0) ? x : x % y;
        4'd10: z = x ^ y;
        4'd11: z = y;
        default: z = $signed(x) >>> y[4:0];
      endcase
      r = {32'd0, z};
    end
  endfunction

  // drive one instruction, sample one cycle later, check all outputs
  task automatic run_op(input string tag, input logic [7:0] op, input int di,
                        input logic [63:0] dv, input logic [63:0] sv,
                        input logic [31:0] im);
    logic        e_ill;
    logic [63:0] e_res;
    logic        e_we;
    ref_calc(op, dv, sv, im, e_ill, e_res);
    e_we = !e_ill && (di < 10);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; dst_idx = 4'(di);
    dst_val = dv; src_val = sv; imm = im;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "valid", {63'd0, out_valid}, 64'd1);
    check(e_ill ? tag : "R1", "illegal", {63'd0, out_illegal}, {63'd0, e_ill});
    check("R10", "wr_en", {63'd0, out_wr_en}, {63'd0, e_we});
    check(tag, "result", out_result, e_ill ? 64'd0 : e_res);
    check("R11", "wr_idx", {60'd0, out_wr_idx}, 64'(di));
    if (out_wr_en && out_wr_idx <= 4'd10) regs[out_wr_idx] = out_result;
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] fp_before;
    void'($urandom(32'd20231));
    for (int i = 0; i <= 10; i++) regs[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    // R12: outputs during reset
    check("R12", "valid in reset", {63'd0, out_valid}, 64'd0);
    check("R12", "wr_en in reset", {63'd0, out_wr_en}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12", "valid after reset", {63'd0, out_valid}, 64'd0);
    check("R12", "illegal after reset", {63'd0, out_illegal}, 64'd0);
    check("R12", "result after reset", out_result, 64'd0);

    // R2: operand select
    run_op("R2", 8'h0F, 1, 64'd100, 64'd5, 32'd7);
    run_op("R2", 8'h07, 1, 64'd100, 64'd5, 32'd7);
    // R3: immediate extension
    run_op("R3", 8'hB7, 2, 64'd0, 64'd0, 32'hFFFF_FFF0);
    run_op("R3", 8'hB4, 2, 64'd0, 64'd0, 32'hFFFF_FFF0);
    run_op("R3", 8'h07, 2, 64'd10, 64'd0, 32'hFFFF_FFFF);
    // R4: 32-bit class ignores upper halves and zero-extends
    run_op("R4", 8'h0C, 3, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0001, 32'd0);
    run_op("R4", 8'h84, 3, 64'hDEAD_BEEF_0000_0001, 64'd0, 32'd0);
    // R5: operation set samples
    run_op("R5", 8'h2F, 4, 64'h1_0000_0001, 64'd3, 32'd0);
    run_op("R5", 8'hC7, 4, 64'h8000_0000_0000_0000, 64'd0, 32'd4);
    run_op("R5", 8'hC4, 4, 64'd0, 64'd0, 32'd0);
    run_op("R5", 8'hC4, 4, 64'h0000_0000_8000_0000, 64'd0, 32'd31);
    // R6: shift masking
    run_op("R6", 8'h64, 5, 64'd1, 64'd0, 32'd33);
    run_op("R6", 8'h67, 5, 64'd1, 64'd0, 32'd65);
    run_op("R6", 8'h7F, 5, 64'hF000_0000_0000_0000, 64'd68, 32'd0);
    // R7: division and modulo by zero
    run_op("R7", 8'h3F, 6, 64'd1234, 64'd0, 32'd0);
    run_op("R7", 8'h9F, 6, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd0);
    run_op("R7", 8'h9C, 6, 64'h1234_5678_9ABC_DEF0, 64'h7_0000_0000, 32'd0);
    run_op("R7", 8'h34, 6, 64'd99, 64'd0, 32'd0);
    // R8: byte-order conversion
    run_op("R8", 8'hDC, 7, 64'h1122_3344_5566_7788, 64'd0, 32'd16);
    run_op("R8", 8'hDC, 7, 64'h1122_3344_5566_7788, 64'd0, 32'd32);
    run_op("R8", 8'hDF, 7, 64'h1122_3344_5566_7788, 64'd0, 32'd64);
    run_op("R8", 8'hD4, 7, 64'h1122_3344_5566_7788, 64'd0, 32'd16);
    run_op("R8", 8'hD7, 7, 64'h1122_3344_5566_7788, 64'd0, 32'd64);
    // R9: bad conversion width
    run_op("R9", 8'hDC, 8, 64'h1122_3344_5566_7788, 64'd0, 32'd48);
    run_op("R9", 8'hD7, 8, 64'h1122_3344_5566_7788, 64'd0, 32'd0);
    // R1: undefined operation and class
    run_op("R1", 8'hE7, 9, 64'd5, 64'd5, 32'd5);
    run_op("R1", 8'hF4, 9, 64'd5, 64'd5, 32'd5);
    run_op("R1", 8'h05, 9, 64'd5, 64'd5, 32'd5);
    run_op("R1", 8'h0E, 9, 64'd5, 64'd5, 32'd5);
    // R10: frame pointer write suppressed, result still shown
    fp_before = regs[10];
    run_op("R10", 8'h07, 10, 64'd40, 64'd0, 32'd2);
    run_op("R10", 8'hDF, 10, 64'h0102_0304_0506_0708, 64'd0, 32'd64);
    run_op("R10", 8'hE7, 10, 64'd1, 64'd1, 32'd1);
    run_op("R10", 8'h07, 12, 64'd40, 64'd0, 32'd2);
    // R11: valid drops one cycle after in_valid drops
    @(negedge clk);
    check("R11", "valid idle", {63'd0, out_valid}, 64'd0);
    check("R11", "wr_en idle", {63'd0, out_wr_en}, 64'd0);

    // constrained random traffic through the bench register model
    for (int n = 0; n < 400; n++) begin
      int          di, si, pick;
      logic [2:0]  cls;
      logic [3:0]  code;
      logic [31:0] im;
      logic [63:0] sv;
      pick = int'($urandom % 8);
      cls  = (pick < 3) ? 3'd4 : (pick < 7) ? 3'd7 : 3'($urandom);
      code = 4'($urandom % 16);
      di   = int'($urandom % 11);
      si   = int'($urandom % 11);
      sv   = ($urandom % 8 == 0) ? 64'd0 : regs[si];
      if (code == 4'd13) begin
        pick = int'($urandom % 4);
        im = (pick == 0) ? 32'd16 : (pick == 1) ? 32'd32 : (pick == 2) ? 32'd64 : 32'd24;
      end else if ($urandom % 4 == 0) im = $urandom % 70;
      else im = $urandom;
      run_op("R5", {code, 1'($urandom), cls}, di, regs[di], sv, im);
    end
    check("R10", "frame pointer unchanged", regs[10], fp_before);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule